// File: doc/BRIEF.md
# Bit-serial reflected CRC-16 engine

This block computes a 16-bit cyclic redundancy check over a message supplied one byte at a time. The checksum register starts at all ones. Each accepted byte is folded into the low half of the register. The register then goes through eight right-shift steps, one per clock. On each step a zero enters the top bit, and the reflected polynomial A001H is XORed in whenever the bit that left the bottom was a one. After the last byte, the register holds the CRC.

A producer offers bytes with a valid/ready handshake. Ready falls for the eight processing clocks after each accepted byte. A clear input presets the register for a new message. When the message is complete, a finish request copies the CRC into a small serializer. The serializer emits the two checksum bytes in transmit order, low byte first, over a valid/ready output handshake.

Top module: `crc16_engine`

## Requirements
- R1: After reset, and on the clock after `clear_i` is high, `crc_o` reads FFFFH, `in_ready_o` is 1 and `tx_valid_o` is 0.
- R2: A byte is taken on a clock edge where `in_valid_i` and `in_ready_o` are both 1 and `clear_i` is 0. `in_ready_o` is then 0 for exactly 8 clocks and returns to 1 after them.
- R3: While `in_ready_o` is 0, `in_valid_i` and `in_data_i` have no effect on the final `crc_o`.
- R4: Each byte is XORed into bits 7:0 of the register, followed by 8 steps. Each step shifts right with 0 into bit 15 and XORs A001H when the bit shifted out of bit 0 was 1.
- R5: For the message 01H 03H 00H 00H 00H 01H, starting from preset, `crc_o` ends at 0A84H.
- R6: While `in_ready_o` is 1 and no byte or clear arrives, `crc_o` holds its value.
- R7: A finish request emits CRC bits 7:0 first, then bits 15:8, on two consecutive `tx_valid_o`/`tx_ready_i` handshakes. While `tx_ready_i` is 0, `tx_valid_o` stays 1 and `tx_data_o` stays stable.
- R8: `finish_i` is ignored while `in_ready_o` is 0 or a transfer is already under way.
- R9: `clear_i` during byte processing abandons the byte, presets the register to FFFFH and raises `in_ready_o` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Preset for a new message; aborts any byte or transfer in progress |
| in_valid_i | input | 1 | Byte offered |
| in_data_i | input | 8 | Message byte |
| in_ready_o | output | 1 | Engine can take a byte |
| crc_o | output | 16 | Current CRC register |
| finish_i | input | 1 | Request to send the CRC bytes |
| tx_valid_o | output | 1 | Serializer byte valid |
| tx_data_o | output | 8 | Serializer byte, low CRC byte first |
| tx_ready_i | input | 1 | Consumer takes the serializer byte |

## Verification
On every cycle the assertions check four things. The ready gap after an accepted byte never runs longer than eight clocks. The register reads the preset value after a clear. The register does not move while the engine is idle. The serializer byte holds under backpressure. Only the bench scenarios show that the arithmetic is right: the fixed reference vector, a multi-byte message compared against an independent model, and the order of the two transmitted bytes. The bench scenarios also show that bytes and finish requests arriving during a busy gap are really discarded, and that a mid-byte clear abandons the byte.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
    localparam int CRC_W    = 16;
    localparam int BYTE_W   = 8;
    localparam logic [CRC_W-1:0] CRC_POLY   = 16'hA001;
    localparam logic [CRC_W-1:0] CRC_PRESET = 16'hFFFF;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } crc_pair_t;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_LO   = 2'd1,
        TX_HI   = 2'd2
    } tx_state_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c);
        logic [CRC_W-1:0] sh;
        sh = {1'b0, c[CRC_W-1:1]};
        return c[0] ? (sh ^ CRC_POLY) : sh;
    endfunction
endpackage

// File: rtl/crc16_bitcore.sv
module crc16_bitcore
    import crc16_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc,
    output logic              busy
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc    <= CRC_PRESET;
            busy   <= 1'b0;
            step_q <= '0;
        end else if (busy) begin
            crc <= crc_step(crc);
            if (step_q == LAST) begin
                busy   <= 1'b0;
                step_q <= '0;
            end else begin
                step_q <= step_q + 1'b1;
            end
        end else if (load) begin
            crc    <= crc ^ CRC_W'(data);
            busy   <= 1'b1;
            step_q <= '0;
        end
    end
endmodule

// File: rtl/crc16_txser.sv
module crc16_txser
    import crc16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              start,
    input  logic [CRC_W-1:0]  crc_in,
    output logic              idle,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready
);
    tx_state_t state_q;
    crc_pair_t hold_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state_q <= TX_IDLE;
            hold_q  <= '0;
        end else begin
            unique case (state_q)
                TX_IDLE: if (start) begin
                    hold_q  <= crc_pair_t'(crc_in);
                    state_q <= TX_LO;
                end
                TX_LO:   if (tx_ready) state_q <= TX_HI;
                TX_HI:   if (tx_ready) state_q <= TX_IDLE;
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    always_comb begin
        idle     = (state_q == TX_IDLE);
        tx_valid = !idle;
        tx_data  = (state_q == TX_HI) ? hold_q.hi : hold_q.lo;
    end
endmodule

// File: rtl/crc16_engine.sv
module crc16_engine
    import crc16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              in_valid_i,
    input  logic [BYTE_W-1:0] in_data_i,
    output logic              in_ready_o,
    output logic [CRC_W-1:0]  crc_o,
    input  logic              finish_i,
    output logic              tx_valid_o,
    output logic [BYTE_W-1:0] tx_data_o,
    input  logic              tx_ready_i
);
    logic busy, ser_idle, load, start;

    assign in_ready_o = !busy;
    assign load       = in_valid_i && !busy;
    assign start      = finish_i && !busy && ser_idle;

    crc16_bitcore #(.DATA_W(BYTE_W)) u_core (
        .clk(clk), .rst(rst), .clear(clear_i), .load(load),
        .data(in_data_i), .crc(crc_o), .busy(busy)
    );

    crc16_txser u_ser (
        .clk(clk), .rst(rst), .clear(clear_i), .start(start),
        .crc_in(crc_o), .idle(ser_idle), .tx_valid(tx_valid_o),
        .tx_data(tx_data_o), .tx_ready(tx_ready_i)
    );
endmodule

// File: rtl/crc16_engine_chk.sv
module crc16_engine_chk
    import crc16_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              clear_i,
    input logic              in_valid_i,
    input logic              in_ready_o,
    input logic [CRC_W-1:0]  crc_o,
    input logic              tx_valid_o,
    input logic [BYTE_W-1:0] tx_data_o,
    input logic              tx_ready_i
);
    logic [4:0] gap_q;
    always_ff @(posedge clk) begin
        if (rst || in_ready_o) gap_q <= '0;
        else                   gap_q <= gap_q + 1'b1;
    end

    p_gap_len_r2: assert property (@(posedge clk) disable iff (rst)
        !in_ready_o |-> gap_q < 5'(BYTE_W));

    p_take_drops_ready_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && in_ready_o && !clear_i) |=> !in_ready_o);

    p_clear_preset_r1: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (crc_o == CRC_PRESET) && in_ready_o && !tx_valid_o);

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (in_ready_o && !in_valid_i && !clear_i) |=> $stable(crc_o));

    p_tx_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && !tx_ready_i && !clear_i) |=> tx_valid_o && $stable(tx_data_o));
endmodule

bind crc16_engine crc16_engine_chk u_chk (
    .clk(clk), .rst(rst), .clear_i(clear_i), .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o), .crc_o(crc_o), .tx_valid_o(tx_valid_o),
    .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i)
);

// File: tb/crc16_engine_tb.sv
module crc16_engine_tb;
    logic clk = 0, rst = 1, clear_i = 0, in_valid_i = 0, finish_i = 0, tx_ready_i = 0;
    logic [7:0] in_data_i = 0;
    logic in_ready_o, tx_valid_o;
    logic [15:0] crc_o;
    logic [7:0] tx_data_o;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    crc16_engine u_dut (
        .clk(clk), .rst(rst), .clear_i(clear_i), .in_valid_i(in_valid_i),
        .in_data_i(in_data_i), .in_ready_o(in_ready_o), .crc_o(crc_o),
        .finish_i(finish_i), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
        .tx_ready_i(tx_ready_i)
    );

    function automatic logic [15:0] model(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int i = 0; i < 8; i++) r = (r & 16'h1) ? ((r >> 1) ^ 16'hA001) : (r >> 1);
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // offer one byte at a negedge when ready; return number of low-ready cycles seen
    task automatic send_byte(input logic [7:0] b, output int gap);
        while (!in_ready_o) @(negedge clk);
        in_valid_i = 1; in_data_i = b;
        @(negedge clk);
        in_valid_i = 0;
        gap = 0;
        while (!in_ready_o && gap < 20) begin gap++; @(negedge clk); end
    endtask

    task automatic do_clear();
        clear_i = 1; @(negedge clk); clear_i = 0;
    endtask

    task automatic t_reset();
        chk("R1 crc", crc_o, 16'hFFFF);
        chk("R1 ready", in_ready_o, 1);
        chk("R1 txvalid", tx_valid_o, 0);
    endtask

    task automatic t_single();
        int g;
        do_clear();
        send_byte(8'hA5, g);
        chk("R2 gap", g, 8);
        chk("R4 single", crc_o, model(16'hFFFF, 8'hA5));
    endtask

    task automatic t_vector();
        int g;
        logic [7:0] m [6] = '{8'h01, 8'h03, 8'h00, 8'h00, 8'h00, 8'h01};
        do_clear();
        foreach (m[i]) send_byte(m[i], g);
        chk("R5 vector", crc_o, 16'h0A84);
    endtask

    task automatic t_idle_hold();
        logic [15:0] v = crc_o;
        repeat (5) @(negedge clk);
        chk("R6 hold", crc_o, v);
    endtask

    task automatic t_serialize();
        logic [15:0] v = crc_o;
        tx_ready_i = 0;
        finish_i = 1; @(negedge clk); finish_i = 0;
        chk("R7 valid", tx_valid_o, 1);
        chk("R7 lo", tx_data_o, v[7:0]);
        repeat (3) @(negedge clk);
        chk("R7 stall valid", tx_valid_o, 1);
        chk("R7 stall lo", tx_data_o, v[7:0]);
        tx_ready_i = 1; @(negedge clk);
        chk("R7 hi valid", tx_valid_o, 1);
        chk("R7 hi", tx_data_o, v[15:8]);
        @(negedge clk); tx_ready_i = 0;
        chk("R7 done", tx_valid_o, 0);
    endtask

    task automatic t_busy_ignore();
        logic [15:0] exp;
        int g;
        do_clear();
        exp = model(16'hFFFF, 8'h3C);
        in_valid_i = 1; in_data_i = 8'h3C; @(negedge clk);
        in_data_i = 8'h77; finish_i = 1;
        repeat (3) @(negedge clk);
        chk("R8 no tx", tx_valid_o, 0);
        in_valid_i = 0; finish_i = 0;
        g = 0;
        while (!in_ready_o && g < 20) begin g++; @(negedge clk); end
        chk("R3 ignored", crc_o, exp);
        chk("R8 still idle", tx_valid_o, 0);
    endtask

    task automatic t_multi();
        int g;
        logic [15:0] exp = 16'hFFFF;
        logic [7:0] m [4] = '{8'hDE, 8'hAD, 8'hBE, 8'hEF};
        do_clear();
        foreach (m[i]) begin send_byte(m[i], g); exp = model(exp, m[i]); end
        chk("R4 multi", crc_o, exp);
        chk("R2 ready back", in_ready_o, 1);
    endtask

    task automatic t_clear_mid();
        do_clear();
        in_valid_i = 1; in_data_i = 8'h55; @(negedge clk); in_valid_i = 0;
        repeat (2) @(negedge clk);
        chk("R9 busy", in_ready_o, 0);
        do_clear();
        chk("R9 crc", crc_o, 16'hFFFF);
        chk("R9 ready", in_ready_o, 1);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 0;
                @(negedge clk);
                t_reset();
                t_single();
                t_vector();
                t_idle_hold();
                t_serialize();
                t_busy_ignore();
                t_multi();
                t_clear_mid();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule